// File: doc/BRIEF.md
# Two-Share Arithmetic-to-Boolean Mask Converter

This block takes secrets that are split as a first-order arithmetic sharing of 32-bit words and returns the same secrets as a Boolean sharing. On the input side, a secret equals the sum of its two shares modulo 2^32. On the output side, it equals the XOR of its two shares. Several independent lanes are converted together in one operation. No internal signal ever holds a secret in unshared form.

Each arithmetic share is first turned into a Boolean sharing of itself by using a fresh random word as the second share. The two Boolean sharings are then added by a bit-serial masked adder. The adder consumes one bit position per clock. Its carry is kept as two shares and is updated through masked AND gadgets, and each gadget takes a fresh random bit. The caller supplies all randomness through one wide input. The block accepts new work only while it is idle, and it signals completion with a one-cycle pulse.

Top module: `masked_a2b_conv`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `in_ready` stays 0 until the result is presented.
- R3: For every lane l, bits [32l+31:32l] of `bool_sh0_o` XOR `bool_sh1_o` equal the sum of the same bit fields of `arith_sh0_i` and `arith_sh1_i`, taken modulo 2^32, as captured at acceptance.
- R4: Lanes are independent. A lane's result depends only on that lane's input shares.
- R5: `out_valid` rises exactly WORD_W clock edges after the accepting edge, whatever the data and randomness.
- R6: `out_valid` is high for exactly one cycle. `in_ready` is 1 during that cycle.
- R7: `in_valid` asserted while the block is busy has no effect. The pending result is unchanged, and no extra result is produced.
- R8: The recombined result does not depend on the randomness value, including all-zero and all-one randomness.
- R9: Carries ripple across the full word and wrap modulo 2^32. Examples: 0xFFFFFFFF+1 gives 0, and 0x80000000+0x80000000 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input shares are offered |
| in_ready | output | 1 | Block is idle and will accept |
| arith_sh0_i | input | NUM_LANES*WORD_W | First arithmetic share of each lane, lane l at bits [32l+31:32l] |
| arith_sh1_i | input | NUM_LANES*WORD_W | Second arithmetic share of each lane |
| rand_i | input | 2*NUM_LANES*WORD_W | Fresh randomness. At acceptance, lane l takes r from bits [64l+31:64l] and s from [64l+63:64l+32]. On each serial step it takes gadget bits [64l+1:64l] |
| out_valid | output | 1 | One-cycle pulse: Boolean shares are valid |
| bool_sh0_o | output | NUM_LANES*WORD_W | First Boolean share of each lane |
| bool_sh1_o | output | NUM_LANES*WORD_W | Second Boolean share of each lane |

## Verification
Operands that are all zero and operands whose sum is zero only because of wrap-around show whether the serial carry reaches the top bit and is then discarded. Uniformly random operands give each lane a different value, which exposes crossed lane wiring and per-lane slicing errors. The same operands are repeated with random, all-zero and all-one randomness to show that masks and gadget bits cancel on recombination. A request raised while busy shows whether an in-flight operation can be disturbed or a second result produced.

// File: rtl/a2b_pkg.sv
// Shared definitions for the masked arithmetic-to-Boolean converter.
// Assumes: one serial step per clock, two masked AND gadgets per step.
package a2b_pkg;
    localparam int unsigned GADGET_BITS = 2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/a2b_masked_and.sv
// Two-share AND gadget with domain-separated cross terms.
// Computes q0^q1 = (a0^a1)&(b0^b1). Assumes m is a fresh uniform bit for each use.
module a2b_masked_and (
    input  logic a0,
    input  logic a1,
    input  logic b0,
    input  logic b1,
    input  logic m,
    output logic q0,
    output logic q1
);
    // each output share mixes its own domain with one masked cross term
    assign q0 = (a0 & b0) ^ ((a0 & b1) ^ m);
    assign q1 = (a1 & b1) ^ ((a1 & b0) ^ m);
endmodule

// File: rtl/a2b_seq.sv
// Sequencer: accepts work when idle, runs WORD_W serial steps, and pulses done.
// Assumes: the latency does not depend on the data.
module a2b_seq #(
    parameter int unsigned WORD_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic step,
    output logic done
);
    import a2b_pkg::*;

    localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] bit_q;

    // handshake and step strobes
    assign in_ready = (state_q == SEQ_IDLE);
    assign load     = in_valid && in_ready;
    assign step     = (state_q == SEQ_RUN);

    // state, bit counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            bit_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= step && (bit_q == LAST);
            if (load) begin
                state_q <= SEQ_RUN;
                bit_q   <= '0;
            end else if (step) begin
                if (bit_q == LAST) begin
                    state_q <= SEQ_IDLE;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/a2b_lane.sv
// One lane: refreshes each arithmetic share into a Boolean sharing, then adds
// the two sharings with a bit-serial masked ripple adder, LSB first.
// Assumes: gad_m and the masks r and s are fresh on every use.
module a2b_lane #(
    parameter int unsigned WORD_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          step,
    input  logic [WORD_W-1:0]             arith0,
    input  logic [WORD_W-1:0]             arith1,
    input  logic [WORD_W-1:0]             mask_r,
    input  logic [WORD_W-1:0]             mask_s,
    input  logic [a2b_pkg::GADGET_BITS-1:0] gad_m,
    output logic [WORD_W-1:0]             bool0,
    output logic [WORD_W-1:0]             bool1
);
    logic [WORD_W-1:0] x0_q, x1_q, y0_q, y1_q;
    logic              c0_q, c1_q;
    logic              p0, p1, g0, g1, t0, t1;

    // shared propagate bit for the current position
    assign p0 = x0_q[0] ^ y0_q[0];
    assign p1 = x1_q[0] ^ y1_q[0];

    // shared generate term x&y
    a2b_masked_and u_gen (
        .a0(x0_q[0]), .a1(x1_q[0]), .b0(y0_q[0]), .b1(y1_q[0]),
        .m(gad_m[0]), .q0(g0), .q1(g1)
    );

    // shared carry-propagate term c&p
    a2b_masked_and u_prp (
        .a0(c0_q), .a1(c1_q), .b0(p0), .b1(p1),
        .m(gad_m[1]), .q0(t0), .q1(t1)
    );

    // operand refresh on load, serial add on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x0_q  <= '0;
            x1_q  <= '0;
            y0_q  <= '0;
            y1_q  <= '0;
            c0_q  <= 1'b0;
            c1_q  <= 1'b0;
            bool0 <= '0;
            bool1 <= '0;
        end else if (load) begin
            x0_q <= arith0 ^ mask_r;
            x1_q <= mask_r;
            y0_q <= arith1 ^ mask_s;
            y1_q <= mask_s;
            c0_q <= 1'b0;
            c1_q <= 1'b0;
        end else if (step) begin
            x0_q  <= x0_q >> 1;
            x1_q  <= x1_q >> 1;
            y0_q  <= y0_q >> 1;
            y1_q  <= y1_q >> 1;
            bool0 <= {p0 ^ c0_q, bool0[WORD_W-1:1]};
            bool1 <= {p1 ^ c1_q, bool1[WORD_W-1:1]};
            c0_q  <= g0 ^ t0;
            c1_q  <= g1 ^ t1;
        end
    end
endmodule

// File: rtl/masked_a2b_conv.sv
// Vectorized two-share arithmetic-to-Boolean converter.
// Assumes: rand_i carries fresh randomness on every cycle. Results are meaningful
// only while out_valid is high.
module masked_a2b_conv #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned WORD_W    = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [NUM_LANES*WORD_W-1:0]     arith_sh0_i,
    input  logic [NUM_LANES*WORD_W-1:0]     arith_sh1_i,
    input  logic [2*NUM_LANES*WORD_W-1:0]   rand_i,
    output logic                            out_valid,
    output logic [NUM_LANES*WORD_W-1:0]     bool_sh0_o,
    output logic [NUM_LANES*WORD_W-1:0]     bool_sh1_o
);
    localparam int unsigned LANE_RAND_W = 2 * WORD_W;

    logic load, step;

    a2b_seq #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .load(load), .step(step), .done(out_valid)
    );

    // one serial masked adder per lane
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        a2b_lane #(.WORD_W(WORD_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(load), .step(step),
            .arith0(arith_sh0_i[l*WORD_W +: WORD_W]),
            .arith1(arith_sh1_i[l*WORD_W +: WORD_W]),
            .mask_r(rand_i[l*LANE_RAND_W +: WORD_W]),
            .mask_s(rand_i[l*LANE_RAND_W + WORD_W +: WORD_W]),
            .gad_m(rand_i[l*LANE_RAND_W +: a2b_pkg::GADGET_BITS]),
            .bool0(bool_sh0_o[l*WORD_W +: WORD_W]),
            .bool1(bool_sh1_o[l*WORD_W +: WORD_W])
        );
    end
endmodule

// File: rtl/a2b_conv_chk.sv
// Port-level checker for masked_a2b_conv: handshake, fixed latency, one-cycle
// pulse and recombined result. Assumes: it is attached by the bind below.
module a2b_conv_chk #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned WORD_W    = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          in_ready,
    input logic [NUM_LANES*WORD_W-1:0]   arith_sh0_i,
    input logic [NUM_LANES*WORD_W-1:0]   arith_sh1_i,
    input logic [2*NUM_LANES*WORD_W-1:0] rand_i,
    input logic                          out_valid,
    input logic [NUM_LANES*WORD_W-1:0]   bool_sh0_o,
    input logic [NUM_LANES*WORD_W-1:0]   bool_sh1_o
);
    logic                        act_q;
    logic [15:0]                 age_q;
    logic [NUM_LANES*WORD_W-1:0] exp_q;
    logic                        acc;

    assign acc = in_valid && in_ready;

    // track the age of the accepted operation and its expected sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            age_q <= '0;
            exp_q <= '0;
        end else if (acc) begin
            act_q <= 1'b1;
            age_q <= '0;
            for (int l = 0; l < NUM_LANES; l++) begin
                exp_q[l*WORD_W +: WORD_W] <= arith_sh0_i[l*WORD_W +: WORD_W]
                                           + arith_sh1_i[l*WORD_W +: WORD_W];
            end
        end else if (act_q) begin
            age_q <= age_q + 16'd1;
            if (out_valid) act_q <= 1'b0;
        end
    end

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !in_ready);
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (act_q && age_q == 16'(WORD_W)));
    assert_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && age_q < 16'(WORD_W)) |-> !out_valid);
    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_ready_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);
    assert_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((bool_sh0_o ^ bool_sh1_o) == exp_q));
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> !out_valid);
endmodule

bind masked_a2b_conv a2b_conv_chk #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_masked_a2b_conv.sv
module sim_masked_a2b_conv;
    localparam int NL = 4;
    localparam int W  = 32;
    localparam int VW = NL * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VW-1:0] a0 = '0, a1 = '0;
    logic [2*VW-1:0] rnd = '0;
    logic          out_valid;
    logic [VW-1:0] b0, b1;

    int checks = 0, errors = 0, cyc = 0, sent = 0, seen = 0;
    int rmode = 0;
    logic [VW-1:0] exp_q[$];
    int acc_q[$];
    logic prev_ov = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    masked_a2b_conv #(.NUM_LANES(NL), .WORD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .arith_sh0_i(a0), .arith_sh1_i(a1), .rand_i(rnd),
        .out_valid(out_valid), .bool_sh0_o(b0), .bool_sh1_o(b1)
    );

    // randomness source: random, all-zero or all-one
    always @(negedge clk) begin
        for (int i = 0; i < 2*NL; i++)
            rnd[i*32 +: 32] <= (rmode == 0) ? $urandom : ((rmode == 1) ? 32'h0 : 32'hFFFF_FFFF);
    end

    function automatic logic [VW-1:0] lane_sum(logic [VW-1:0] x, logic [VW-1:0] y);
        logic [VW-1:0] s;
        for (int l = 0; l < NL; l++) s[l*W +: W] = x[l*W +: W] + y[l*W +: W];
        return s;
    endfunction

    // driver: offer one operation, push its expectation
    task automatic send(input logic [VW-1:0] x, input logic [VW-1:0] y);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        a0 = x; a1 = y; in_valid = 1'b1;
        exp_q.push_back(lane_sum(x, y));
        acc_q.push_back(cyc + 1 + W);
        sent++;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (in_ready !== 1'b0) begin
            errors++;
            $display("FAIL R2 in_ready after accept act=%b exp=0", in_ready);
        end
    endtask

    // request while busy; must be ignored (R7)
    task automatic poke_busy();
        for (int i = 0; i < 5; i++) begin
            a0 = {$urandom, $urandom, $urandom, $urandom};
            a1 = {$urandom, $urandom, $urandom, $urandom};
            in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // monitor: compare each result with the scoreboard head
    always @(negedge clk) begin
        if (prev_ov) begin
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R6 out_valid not a pulse act=%b exp=0", out_valid);
            end
        end
        prev_ov = out_valid;
        if (out_valid === 1'b1) begin
            seen++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 unexpected result act=%h exp=none", b0 ^ b1);
            end else begin
                logic [VW-1:0] e;
                int t;
                e = exp_q.pop_front();
                t = acc_q.pop_front();
                for (int l = 0; l < NL; l++) begin
                    checks++;
                    if ((b0[l*W +: W] ^ b1[l*W +: W]) !== e[l*W +: W]) begin
                        errors++;
                        $display("FAIL R3/R4 lane %0d act=%h exp=%h", l,
                                 b0[l*W +: W] ^ b1[l*W +: W], e[l*W +: W]);
                    end
                end
                checks++;
                if (cyc != t) begin
                    errors++;
                    $display("FAIL R5 latency act=%0d exp=%0d", cyc, t);
                end
                checks++;
                if (in_ready !== 1'b1) begin
                    errors++;
                    $display("FAIL R6 in_ready at done act=%b exp=1", in_ready);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [VW-1:0] x, y;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks += 2;  // R1 reset state
        if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid act=%b exp=0", out_valid); end
        if (in_ready !== 1'b1) begin errors++; $display("FAIL R1 in_ready act=%b exp=1", in_ready); end

        send('0, '0);                                               // R3 zeros
        send({4{32'hFFFF_FFFF}}, {4{32'h0000_0001}});               // R9 wrap to 0
        send({32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0},
             {32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF}); // R9 carries
        for (int i = 0; i < 20; i++) begin                          // R3 R4 random lanes
            x = {$urandom, $urandom, $urandom, $urandom};
            y = {$urandom, $urandom, $urandom, $urandom};
            send(x, y);
        end
        x = {32'h1234_5678, 32'h0, 32'h0, 32'h0};                   // R4 one lane differs
        send(x, '0);
        x = {32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'h5555_AAAA, 32'hFFFF_0001};
        y = {32'h2152_4111, 32'hF0F1_0F10, 32'hAAAA_5556, 32'h0000_FFFF};
        rmode = 1; send(x, y);                                      // R8 zero randomness
        rmode = 2; send(x, y);                                      // R8 all-one randomness
        rmode = 0; send(x, y);                                      // R8 random
        send(x, y);
        poke_busy();                                                // R7
        send({4{32'h0000_00FF}}, {4{32'h0000_0001}});
        while (exp_q.size() != 0) @(negedge clk);
        repeat (W + 4) @(negedge clk);
        checks++;                                                   // R7 no extra results
        if (seen != sent) begin
            errors++;
            $display("FAIL R7 result count act=%0d exp=%0d", seen, sent);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule